// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that carries a device from one lifecycle state to another. A request in the idle state starts a fixed chain of steps. The machine switches the clock source and bumps the transition counter, then writes that counter and confirms that the requested target is legal. It hashes the supplied unlock token and, when the transition needs it, wipes flash. It compares the hashed token in two halves over two cycles and writes the new state. Every path ends in a post-transition state that holds a done flag and a sticky failure code.

The hash engine, the flash and the one-time-programmable store are outside the block. Each appears only as request and acknowledge pins. Two independent escalation inputs pull the machine into a terminal escalation state. A state register value that is not a legal codeword traps it in an invalid state. The state register is 16 bits wide and sparsely encoded, so a single upset cannot turn one legal state into another.

Top module: `lcx_seq_top`

## Requirements
- R1: With `rst_ni` low at a rising edge the state becomes Reset and `done_o`, `err_o` and `err_code_o` clear. Reset always moves to Idle on the next edge, whatever the inputs.
- R2: From Idle a `trans_req_i` moves to clock-switch. That state holds until `clk_sw_ack_i`, then moves to counter-bump, then to counter-write. Counter-write holds until `prog_ack_i`, then moves to legality-check. With `trans_legal_i` high, legality-check moves to hash.
- R3: Hash holds until `hash_valid_i`, then moves to wipe. Wipe passes in one cycle when `wipe_need_i` is low, and otherwise holds until `wipe_ack_i`. It then moves to token-low, token-high and state-write in turn.
- R4: Token-low compares bits [31:0] of `hash_i` with `token_ref_i`, and token-high compares bits [63:32]. A mismatch in either half goes straight to post-transition with code 5.
- R5: A failure exits to post-transition on the next edge, and `err_code_o` records where it happened: counter-bump without `cnt_ok_i` gives 1, counter-write acknowledged with `prog_err_i` gives 2, legality-check without `trans_legal_i` gives 3, hash valid with `hash_err_i` gives 4, and state-write acknowledged with `prog_err_i` gives 6. `done_o` and `err_o` rise on that same edge, and `done_o`, `err_o` and `err_code_o` then hold until reset.
- R6: State-write acknowledged without `prog_err_i` enters post-transition with `done_o`=1, `err_o`=0 and code 0.
- R7: Post-transition, Scrap and Invalid ignore every input except escalation. Scrap also ignores escalation.
- R8: In Idle, `scrap_req_i` moves to Scrap and takes priority over `trans_req_i`.
- R9: If `esc0_i` or `esc1_i` is high in any state other than Reset, Scrap and Escalate, the next state is Escalate. Escalation wins over every other input. Escalate is left only by reset.
- R10: A state register value that is not one of the fifteen codewords moves to Invalid on the next edge.
- R11: `state_o` shows the state as its 4-bit index repeated four times, so any two codes differ in at least 4 bits. The indices are: Reset 1, Idle 2, clock-switch 3, counter-bump 4, counter-write 5, legality-check 6, hash 7, wipe 8, token-low 9, token-high A, state-write B, post-transition C, Scrap D, Escalate E, Invalid F.
- R12: The outputs `clk_sw_req_o` (clock-switch), `prog_req_o` (counter-write or state-write), `hash_req_o` (hash) and `wipe_req_o` (wipe with `wipe_need_i` high) follow the present state combinationally, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| trans_req_i | input | 1 | Start a transition (sampled in Idle) |
| scrap_req_i | input | 1 | Request scrap (sampled in Idle) |
| trans_legal_i | input | 1 | Requested target is reachable |
| wipe_need_i | input | 1 | Transition needs a flash wipe |
| clk_sw_ack_i | input | 1 | Clock source switch done |
| cnt_ok_i | input | 1 | Counter can be incremented |
| prog_ack_i | input | 1 | Store write finished |
| prog_err_i | input | 1 | Store write failed (qualified by ack) |
| hash_valid_i | input | 1 | Token hash result ready |
| hash_err_i | input | 1 | Hash failed (qualified by valid) |
| hash_i | input | 64 | Hashed token |
| token_ref_i | input | 64 | Expected hashed token |
| wipe_ack_i | input | 1 | Flash wipe finished |
| esc0_i | input | 1 | Escalation input 0 |
| esc1_i | input | 1 | Escalation input 1 |
| state_o | output | 16 | Present state codeword |
| clk_sw_req_o | output | 1 | Clock switch request |
| prog_req_o | output | 1 | Store write request |
| hash_req_o | output | 1 | Hash request |
| wipe_req_o | output | 1 | Flash wipe request |
| done_o | output | 1 | Post-transition reached (sticky) |
| err_o | output | 1 | Transition failed (sticky) |
| err_code_o | output | 3 | Failure location (sticky) |

## Verification
Every state move, and the done, error and code outputs, appear one rising edge after the inputs that cause them. Input values in this block live in the cycle before that edge. The four request outputs decode the present state and the live `wipe_need_i`, so they hold in the same cycle. The bench drives inputs on the falling edge and checks the request outputs 1 ns later. It then predicts the next state and flags from its own step function, and compares them at the following falling edge. The illegal-encoding case overrides the state register across one full edge and checks for Invalid one edge after the override is released.

// File: rtl/lcx_pkg.sv
// Shared types for the lifecycle transition sequencer.
// Assumes: state codes are the 4-bit state index repeated four times,
// which gives a minimum pairwise Hamming distance of 4.
package lcx_pkg;

    localparam int STATE_W = 16;
    localparam int CODE_W  = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET       = 16'h1111,
        ST_IDLE        = 16'h2222,
        ST_CLK_SWITCH  = 16'h3333,
        ST_CNT_BUMP    = 16'h4444,
        ST_CNT_WRITE   = 16'h5555,
        ST_LEGAL_CHK   = 16'h6666,
        ST_HASH        = 16'h7777,
        ST_WIPE        = 16'h8888,
        ST_TOK_LO      = 16'h9999,
        ST_TOK_HI      = 16'hAAAA,
        ST_STATE_WRITE = 16'hBBBB,
        ST_POST        = 16'hCCCC,
        ST_SCRAP       = 16'hDDDD,
        ST_ESCALATE    = 16'hEEEE,
        ST_INVALID     = 16'hFFFF
    } lcx_state_e;

    typedef enum logic [CODE_W-1:0] {
        FC_NONE        = 3'd0,
        FC_CNT_BUMP    = 3'd1,
        FC_CNT_WRITE   = 3'd2,
        FC_ILLEGAL     = 3'd3,
        FC_HASH        = 3'd4,
        FC_TOKEN       = 3'd5,
        FC_STATE_WRITE = 3'd6
    } lcx_fail_e;

endpackage

// File: rtl/lcx_tok_cmp.sv
// Token slice comparator.
// Splits the hashed token and its reference into NUM_PARTS equal slices and
// flags each slice that matches. Assumes TOKEN_W is a multiple of NUM_PARTS.
module lcx_tok_cmp #(
    parameter int TOKEN_W   = 64,
    parameter int NUM_PARTS = 2
) (
    input  logic [TOKEN_W-1:0]   hash_i,
    input  logic [TOKEN_W-1:0]   ref_i,
    output logic [NUM_PARTS-1:0] part_ok_o
);
    localparam int PART_W = TOKEN_W / NUM_PARTS;

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        // One equality compare per slice
        assign part_ok_o[p] = (hash_i[p*PART_W +: PART_W] == ref_i[p*PART_W +: PART_W]);
    end
endmodule

// File: rtl/lcx_next.sv
// Next-state and failure-code logic for the sequencer.
// Purely combinational. Escalation beats every other input in the states
// that accept it. Any code outside the legal set maps to Invalid.
module lcx_next
    import lcx_pkg::*;
#(
    parameter int NUM_PARTS = 2
) (
    input  logic [STATE_W-1:0]   state_i,
    input  logic                 trans_req_i,
    input  logic                 scrap_req_i,
    input  logic                 trans_legal_i,
    input  logic                 wipe_need_i,
    input  logic                 clk_sw_ack_i,
    input  logic                 cnt_ok_i,
    input  logic                 prog_ack_i,
    input  logic                 prog_err_i,
    input  logic                 hash_valid_i,
    input  logic                 hash_err_i,
    input  logic                 wipe_ack_i,
    input  logic                 esc_i,
    input  logic [NUM_PARTS-1:0] part_ok_i,
    output logic [STATE_W-1:0]   state_d_o,
    output lcx_fail_e            fail_o
);
    localparam int LO = 0;
    localparam int HI = NUM_PARTS - 1;

    logic esc_takes;

    // States from which an escalation input is honoured
    always_comb begin
        case (state_i)
            ST_IDLE, ST_CLK_SWITCH, ST_CNT_BUMP, ST_CNT_WRITE, ST_LEGAL_CHK,
            ST_HASH, ST_WIPE, ST_TOK_LO, ST_TOK_HI, ST_STATE_WRITE,
            ST_POST, ST_INVALID: esc_takes = esc_i;
            default:             esc_takes = 1'b0;
        endcase
    end

    // Transition table with failure exits
    always_comb begin
        state_d_o = state_i;
        fail_o    = FC_NONE;
        if (esc_takes) begin
            state_d_o = ST_ESCALATE;
        end else begin
            case (state_i)
                ST_RESET: state_d_o = ST_IDLE;
                ST_IDLE: begin
                    if (scrap_req_i)      state_d_o = ST_SCRAP;
                    else if (trans_req_i) state_d_o = ST_CLK_SWITCH;
                end
                ST_CLK_SWITCH: begin
                    if (clk_sw_ack_i) state_d_o = ST_CNT_BUMP;
                end
                ST_CNT_BUMP: begin
                    if (cnt_ok_i) begin
                        state_d_o = ST_CNT_WRITE;
                    end else begin
                        state_d_o = ST_POST;
                        fail_o    = FC_CNT_BUMP;
                    end
                end
                ST_CNT_WRITE: begin
                    if (prog_ack_i) begin
                        if (prog_err_i) begin
                            state_d_o = ST_POST;
                            fail_o    = FC_CNT_WRITE;
                        end else begin
                            state_d_o = ST_LEGAL_CHK;
                        end
                    end
                end
                ST_LEGAL_CHK: begin
                    if (trans_legal_i) begin
                        state_d_o = ST_HASH;
                    end else begin
                        state_d_o = ST_POST;
                        fail_o    = FC_ILLEGAL;
                    end
                end
                ST_HASH: begin
                    if (hash_valid_i) begin
                        if (hash_err_i) begin
                            state_d_o = ST_POST;
                            fail_o    = FC_HASH;
                        end else begin
                            state_d_o = ST_WIPE;
                        end
                    end
                end
                ST_WIPE: begin
                    if (!wipe_need_i || wipe_ack_i) state_d_o = ST_TOK_LO;
                end
                ST_TOK_LO: begin
                    if (part_ok_i[LO]) begin
                        state_d_o = ST_TOK_HI;
                    end else begin
                        state_d_o = ST_POST;
                        fail_o    = FC_TOKEN;
                    end
                end
                ST_TOK_HI: begin
                    if (part_ok_i[HI]) begin
                        state_d_o = ST_STATE_WRITE;
                    end else begin
                        state_d_o = ST_POST;
                        fail_o    = FC_TOKEN;
                    end
                end
                ST_STATE_WRITE: begin
                    if (prog_ack_i) begin
                        state_d_o = ST_POST;
                        if (prog_err_i) fail_o = FC_STATE_WRITE;
                    end
                end
                ST_POST, ST_SCRAP, ST_ESCALATE, ST_INVALID: state_d_o = state_i;
                default: state_d_o = ST_INVALID;
            endcase
        end
    end
endmodule

// File: rtl/lcx_req_dec.sv
// Request decoder: maps the present state to the handshake requests
// toward the clock switch, the store, the hash engine and the flash.
// Assumes the state input is a legal codeword or an ignorable illegal one.
module lcx_req_dec
    import lcx_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    input  logic               wipe_need_i,
    output logic               clk_sw_req_o,
    output logic               prog_req_o,
    output logic               hash_req_o,
    output logic               wipe_req_o
);
    // Decode each request from the state code
    always_comb begin
        clk_sw_req_o = (state_i == ST_CLK_SWITCH);
        prog_req_o   = (state_i == ST_CNT_WRITE) || (state_i == ST_STATE_WRITE);
        hash_req_o   = (state_i == ST_HASH);
        wipe_req_o   = (state_i == ST_WIPE) && wipe_need_i;
    end
endmodule

// File: rtl/lcx_seq_top.sv
// Lifecycle transition sequencer, top level.
// Holds the sparse state register and the sticky done / error / code flags,
// and wires the comparator, next-state logic and request decoder.
// Assumes all inputs are synchronous to clk_i; reset is synchronous, active low.
module lcx_seq_top
    import lcx_pkg::*;
#(
    parameter int TOKEN_W = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trans_req_i,
    input  logic               scrap_req_i,
    input  logic               trans_legal_i,
    input  logic               wipe_need_i,
    input  logic               clk_sw_ack_i,
    input  logic               cnt_ok_i,
    input  logic               prog_ack_i,
    input  logic               prog_err_i,
    input  logic               hash_valid_i,
    input  logic               hash_err_i,
    input  logic [TOKEN_W-1:0] hash_i,
    input  logic [TOKEN_W-1:0] token_ref_i,
    input  logic               wipe_ack_i,
    input  logic               esc0_i,
    input  logic               esc1_i,
    output logic [15:0]        state_o,
    output logic               clk_sw_req_o,
    output logic               prog_req_o,
    output logic               hash_req_o,
    output logic               wipe_req_o,
    output logic               done_o,
    output logic               err_o,
    output logic [2:0]         err_code_o
);
    localparam int NUM_PARTS = 2;

    logic [STATE_W-1:0]   state_q;
    logic [STATE_W-1:0]   state_d;
    lcx_fail_e            fail;
    logic [NUM_PARTS-1:0] part_ok;
    logic                 post_entry;
    logic                 done_q;
    logic                 err_q;
    logic [CODE_W-1:0]    code_q;

    lcx_tok_cmp #(
        .TOKEN_W   (TOKEN_W),
        .NUM_PARTS (NUM_PARTS)
    ) u_cmp (
        .hash_i    (hash_i),
        .ref_i     (token_ref_i),
        .part_ok_o (part_ok)
    );

    lcx_next #(
        .NUM_PARTS (NUM_PARTS)
    ) u_next (
        .state_i       (state_q),
        .trans_req_i   (trans_req_i),
        .scrap_req_i   (scrap_req_i),
        .trans_legal_i (trans_legal_i),
        .wipe_need_i   (wipe_need_i),
        .clk_sw_ack_i  (clk_sw_ack_i),
        .cnt_ok_i      (cnt_ok_i),
        .prog_ack_i    (prog_ack_i),
        .prog_err_i    (prog_err_i),
        .hash_valid_i  (hash_valid_i),
        .hash_err_i    (hash_err_i),
        .wipe_ack_i    (wipe_ack_i),
        .esc_i         (esc0_i | esc1_i),
        .part_ok_i     (part_ok),
        .state_d_o     (state_d),
        .fail_o        (fail)
    );

    lcx_req_dec u_req (
        .state_i      (state_q),
        .wipe_need_i  (wipe_need_i),
        .clk_sw_req_o (clk_sw_req_o),
        .prog_req_o   (prog_req_o),
        .hash_req_o   (hash_req_o),
        .wipe_req_o   (wipe_req_o)
    );

    // Flags latch only on the edge that enters post-transition
    assign post_entry = (state_d == ST_POST) && (state_q != ST_POST);

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    // Sticky completion flags and failure code
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            code_q <= FC_NONE;
        end else if (post_entry) begin
            done_q <= 1'b1;
            err_q  <= (fail != FC_NONE);
            code_q <= fail;
        end
    end

    assign state_o    = state_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign err_code_o = code_q;
endmodule

// File: rtl/lcx_seq_chk.sv
// Protocol checker for the sequencer, bound to the top module.
// Observes ports only.
module lcx_seq_chk
    import lcx_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        esc0_i,
    input logic        esc1_i,
    input logic [15:0] state_o,
    input logic        clk_sw_req_o,
    input logic        prog_req_o,
    input logic        hash_req_o,
    input logic        wipe_req_o,
    input logic        done_o,
    input logic [2:0]  err_code_o
);
    // Reset always hands over to Idle (R1)
    p_reset_exit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_RESET |=> state_o == ST_IDLE);

    // Flags and code hold once done (R5)
    p_code_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> done_o && $stable(err_code_o));

    // Done first appears with post-transition (R6)
    p_done_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> state_o == ST_POST);

    // Scrap is never left (R7)
    p_scrap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_SCRAP |=> state_o == ST_SCRAP);

    // Escalation pulls in from accepting states (R9)
    p_esc_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (esc0_i || esc1_i) && state_o inside {ST_IDLE, ST_CLK_SWITCH, ST_CNT_BUMP,
            ST_CNT_WRITE, ST_LEGAL_CHK, ST_HASH, ST_WIPE, ST_TOK_LO, ST_TOK_HI,
            ST_STATE_WRITE, ST_POST, ST_INVALID}
        |=> state_o == ST_ESCALATE);

    // Escalate is terminal (R9)
    p_esc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_ESCALATE |=> state_o == ST_ESCALATE);

    // Requests are mutually exclusive (R12)
    p_req_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({clk_sw_req_o, prog_req_o, hash_req_o, wipe_req_o}));
endmodule

bind lcx_seq_top lcx_seq_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .esc0_i       (esc0_i),
    .esc1_i       (esc1_i),
    .state_o      (state_o),
    .clk_sw_req_o (clk_sw_req_o),
    .prog_req_o   (prog_req_o),
    .hash_req_o   (hash_req_o),
    .wipe_req_o   (wipe_req_o),
    .done_o       (done_o),
    .err_code_o   (err_code_o)
);

// File: tb/tb_lcx_seq_top.sv
`timescale 1ns/1ps
module tb_lcx_seq_top;
    localparam logic [15:0] S_RST  = 16'h1111, S_IDLE = 16'h2222, S_CLK  = 16'h3333,
                            S_CINC = 16'h4444, S_CWR  = 16'h5555, S_LEG  = 16'h6666,
                            S_HASH = 16'h7777, S_WIPE = 16'h8888, S_TLO  = 16'h9999,
                            S_THI  = 16'hAAAA, S_SWR  = 16'hBBBB, S_POST = 16'hCCCC,
                            S_SCRP = 16'hDDDD, S_ESC  = 16'hEEEE, S_INV  = 16'hFFFF;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic req = 0, scrap = 0, legal = 0, need = 0, cack = 0, cok = 0;
    logic pack = 0, perr = 0, hval = 0, herr = 0, wack = 0, e0 = 0, e1 = 0;
    logic [63:0] hash = '0, tref = '0;
    logic [15:0] state_o;
    logic        clk_sw_req, prog_req, hash_req, wipe_req, done_o, err_o;
    logic [2:0]  code_o;

    lcx_seq_top dut (
        .clk_i(clk), .rst_ni(rst_n), .trans_req_i(req), .scrap_req_i(scrap),
        .trans_legal_i(legal), .wipe_need_i(need), .clk_sw_ack_i(cack),
        .cnt_ok_i(cok), .prog_ack_i(pack), .prog_err_i(perr),
        .hash_valid_i(hval), .hash_err_i(herr), .hash_i(hash),
        .token_ref_i(tref), .wipe_ack_i(wack), .esc0_i(e0), .esc1_i(e1),
        .state_o(state_o), .clk_sw_req_o(clk_sw_req), .prog_req_o(prog_req),
        .hash_req_o(hash_req), .wipe_req_o(wipe_req), .done_o(done_o),
        .err_o(err_o), .err_code_o(code_o)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [15:0] e_state;
    logic e_done, e_err;
    logic [2:0] e_code;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Requirement tag for a step taken from a given state
    function automatic string tag_of(input logic [15:0] s);
        case (s)
            S_RST:                      return "R1";
            S_IDLE, S_CLK, S_CINC, S_CWR, S_LEG: return "R2";
            S_HASH, S_WIPE:             return "R3";
            S_TLO, S_THI:               return "R4";
            S_SWR:                      return "R6";
            S_POST, S_SCRP:             return "R7";
            S_ESC:                      return "R9";
            default:                    return "R10";
        endcase
    endfunction

    // Expected step: {fail code, next state} from the present inputs
    function automatic logic [18:0] ref_step(input logic [15:0] s);
        logic [15:0] ns;
        logic [2:0]  fc;
        logic        esc;
        ns = s; fc = 3'd0; esc = e0 | e1;
        case (s)
            S_RST:  ns = S_IDLE;
            S_IDLE: ns = esc ? S_ESC : scrap ? S_SCRP : req ? S_CLK : S_IDLE;
            S_CLK:  ns = esc ? S_ESC : cack ? S_CINC : S_CLK;
            S_CINC: if (esc) ns = S_ESC; else if (cok) ns = S_CWR; else begin ns = S_POST; fc = 1; end
            S_CWR:  if (esc) ns = S_ESC; else if (pack) begin
                        if (perr) begin ns = S_POST; fc = 2; end else ns = S_LEG;
                    end
            S_LEG:  if (esc) ns = S_ESC; else if (legal) ns = S_HASH; else begin ns = S_POST; fc = 3; end
            S_HASH: if (esc) ns = S_ESC; else if (hval) begin
                        if (herr) begin ns = S_POST; fc = 4; end else ns = S_WIPE;
                    end
            S_WIPE: if (esc) ns = S_ESC; else if (!need || wack) ns = S_TLO;
            S_TLO:  if (esc) ns = S_ESC; else if (hash[31:0] == tref[31:0]) ns = S_THI; else begin ns = S_POST; fc = 5; end
            S_THI:  if (esc) ns = S_ESC; else if (hash[63:32] == tref[63:32]) ns = S_SWR; else begin ns = S_POST; fc = 5; end
            S_SWR:  if (esc) ns = S_ESC; else if (pack) begin ns = S_POST; fc = perr ? 3'd6 : 3'd0; end
            S_POST, S_INV: ns = esc ? S_ESC : s;
            S_SCRP, S_ESC: ns = s;
            default: ns = S_INV;
        endcase
        return {fc, ns};
    endfunction

    // One cycle: check requests now, predict, step one edge, check results
    task automatic tick();
        logic [18:0] r;
        logic [3:0]  ereq;
        string       tag;
        #1;
        ereq = {e_state == S_CLK, (e_state == S_CWR) || (e_state == S_SWR),
                e_state == S_HASH, (e_state == S_WIPE) && need};
        chk({clk_sw_req, prog_req, hash_req, wipe_req} == ereq, "R12 requests",
            {28'd0, clk_sw_req, prog_req, hash_req, wipe_req}, {28'd0, ereq});
        tag = tag_of(e_state);
        if (!rst_n) begin
            e_state = S_RST; e_done = 0; e_err = 0; e_code = 0; tag = "R1";
        end else begin
            r = ref_step(e_state);
            if (r[15:0] == S_POST && e_state != S_POST) begin
                e_done = 1; e_code = r[18:16]; e_err = (r[18:16] != 0);
            end
            e_state = r[15:0];
        end
        @(negedge clk);
        chk(state_o == e_state, {tag, " state"}, {16'd0, state_o}, {16'd0, e_state});
        chk({done_o, err_o, code_o} == {e_done, e_err, e_code}, "R5 flags",
            {27'd0, done_o, err_o, code_o}, {27'd0, e_done, e_err, e_code});
    endtask

    task automatic quiet();
        req = 0; scrap = 0; legal = 0; need = 0; cack = 0; cok = 0; pack = 0;
        perr = 0; hval = 0; herr = 0; wack = 0; e0 = 0; e1 = 0;
        tref = 64'h0123_4567_89AB_CDEF; hash = tref;
    endtask

    task automatic do_reset();
        quiet(); rst_n = 0; tick(); rst_n = 1; tick();
    endtask

    // Walk Idle up to the hash state
    task automatic to_hash();
        req = 1; tick(); req = 0;
        tick();                       // clock switch waits for ack
        cack = 1; tick(); cack = 0;
        cok = 1; tick(); cok = 0;
        pack = 1; tick(); pack = 0;
        legal = 1; tick(); legal = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        quiet();
        @(negedge clk); @(negedge clk);
        chk(state_o == S_RST && !done_o && !err_o && code_o == 0, "R1 reset state",
            {16'd0, state_o}, {16'd0, S_RST});
        e_state = S_RST; e_done = 0; e_err = 0; e_code = 0;
        rst_n = 1;
        tick();
        chk(state_o == 16'h2222, "R11 idle code", {16'd0, state_o}, 32'h2222);

        // Full path with wipe, success
        to_hash();
        chk(state_o == S_HASH, "R2 reached hash", {16'd0, state_o}, {16'd0, S_HASH});
        tick();                       // hash not valid: hold
        hval = 1; tick(); hval = 0;
        need = 1; tick(); tick();     // wipe waits
        wack = 1; tick(); wack = 0; need = 0;
        tick(); tick();               // token halves match
        pack = 1; tick(); pack = 0;
        chk(state_o == S_POST && done_o && !err_o && code_o == 0, "R6 success",
            {16'd0, state_o}, {16'd0, S_POST});
        req = 1; scrap = 1; tick(); tick(); quiet();
        chk(state_o == S_POST, "R7 post ignores requests", {16'd0, state_o}, {16'd0, S_POST});

        // High-half token mismatch
        do_reset(); to_hash(); hval = 1; tick(); hval = 0; tick();
        hash = tref ^ 64'h0000_0010_0000_0000; tick(); tick();
        chk(code_o == 3'd5 && err_o, "R4 high mismatch", {29'd0, code_o}, 32'd5);

        // Low-half mismatch
        do_reset(); to_hash(); hval = 1; tick(); hval = 0; tick();
        hash = tref ^ 64'h1; tick();
        chk(state_o == S_POST && code_o == 3'd5, "R4 low mismatch", {29'd0, code_o}, 32'd5);

        // Counter-write failure, then escalation out of post
        do_reset(); req = 1; tick(); req = 0; cack = 1; tick(); cack = 0;
        cok = 1; tick(); cok = 0; pack = 1; perr = 1; tick(); quiet();
        chk(code_o == 3'd2, "R5 counter write fail", {29'd0, code_o}, 32'd2);
        e1 = 1; tick(); e1 = 0; tick();
        chk(state_o == S_ESC, "R9 escalate from post", {16'd0, state_o}, {16'd0, S_ESC});

        // Scrap wins over transition; escalation ignored there
        do_reset(); scrap = 1; req = 1; tick(); quiet();
        chk(state_o == S_SCRP, "R8 scrap priority", {16'd0, state_o}, {16'd0, S_SCRP});
        e0 = 1; tick(); e0 = 0;
        chk(state_o == S_SCRP, "R7 scrap ignores escalation", {16'd0, state_o}, {16'd0, S_SCRP});

        // Escalation from token-high beats everything
        do_reset(); to_hash(); hval = 1; tick(); hval = 0; tick(); tick();
        e0 = 1; pack = 1; tick(); quiet();
        chk(state_o == S_ESC, "R9 escalate from token-high", {16'd0, state_o}, {16'd0, S_ESC});
        rst_n = 0; e1 = 1; tick(); tick(); rst_n = 1; e1 = 1; tick(); e1 = 0;
        chk(state_o == S_IDLE, "R1 reset exits to idle despite escalation", {16'd0, state_o}, {16'd0, S_IDLE});

        // Illegal encoding
        quiet(); tick();
        force dut.state_q = 16'h1234;
        @(negedge clk);
        release dut.state_q;
        @(negedge clk);
        chk(state_o == S_INV, "R10 illegal code", {16'd0, state_o}, {16'd0, S_INV});
        e_state = S_INV;
        req = 1; scrap = 1; tick(); quiet();
        chk(state_o == S_INV, "R7 invalid holds", {16'd0, state_o}, {16'd0, S_INV});
        e1 = 1; tick(); quiet();

        // Random phase
        do_reset();
        begin
            int stuck = 0;
            for (int i = 0; i < 4000; i++) begin
                req   = $urandom % 2;
                scrap = ($urandom % 16) == 0;
                legal = ($urandom % 8) != 0;
                need  = $urandom % 2;
                cack  = $urandom % 2;
                cok   = ($urandom % 8) != 0;
                pack  = $urandom % 2;
                perr  = ($urandom % 6) == 0;
                hval  = $urandom % 2;
                herr  = ($urandom % 8) == 0;
                wack  = $urandom % 2;
                e0    = ($urandom % 64) == 0;
                e1    = ($urandom % 64) == 0;
                tref  = {$urandom, $urandom};
                hash  = (($urandom % 6) == 0) ? (tref ^ (64'h1 << ($urandom % 64))) : tref;
                if (e_state inside {S_POST, S_SCRP, S_ESC, S_INV}) stuck++; else stuck = 0;
                rst_n = !((stuck > 6) || (($urandom % 300) == 0));
                if (!rst_n) stuck = 0;
                tick();
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule